// File: doc/BRIEF.md
# Stretchable External Memory Bus Sequencer

This block drives the timing of a multiplexed external memory bus for a small 8-bit controller. It runs on a clock at twice the oscillator rate, so one oscillator cycle is two clock phases and one machine cycle is eight phases. It produces a latch-enable strobe that marks when the low address byte is on the shared 8-bit port. It also produces an active-low code-fetch enable, active-low read and write strobes, a drive enable and value for the port, a register that holds captured read data, and a one-clock done pulse.

A requester holds one of three request lines (code fetch, data read, data write) together with the address, the write data and a 3-bit stretch setting until it sees `done`. A code fetch always takes one machine cycle. A data access takes `stretch + 2` machine cycles, so settings 0 to 7 give 2 to 9 machine cycles. When `ale_off` is set, the latch enable stays high while the bus is idle. It still pulses during every access.

The controller has four states. `ST_IDLE` waits for a request. `ST_FETCH`, `ST_READ` and `ST_WRITE` each run one access. A request is taken only on the last phase of a machine cycle, either from `ST_IDLE` or on the final phase of an access. That moves the controller into the access state picked by priority. On the final phase of an access with no request pending, the controller returns to `ST_IDLE`.

Top module: `xbus_seq`

## Requirements
- R1: Phases count 0 to 7 from reset; with `ale_off` = 0 and no access, `ale` is high on phases 0, 1 and 2 and low on phases 3 to 7, a period of 8 clocks.
- R2: While `rst` is high, `ale` is 1, `port_oe` is 0, `psen_n`, `rd_n` and `wr_n` are 1 and `done` is 0.
- R3: With `ale_off` = 1 and no access in progress, `ale` stays at 1.
- R4: During an access, `ale` is high for exactly phases 0 to 2 of the first machine cycle, whatever `ale_off` is, and low for the rest of the access.
- R5: While `ale` is high inside an access, `port_oe` is 1 and `port_out` equals address bits [7:0]; `addr_hi` carries address bits [15:8] during the access.
- R6: A code fetch drives `psen_n` low for 4 clocks, phases 3 to 6 of its single machine cycle; `psen_n` is 1 at all other times.
- R7: A data read drives `rd_n` low for 8*(stretch+2)-4 clocks, from phase 3 of the first machine cycle to phase 6 of the last; the port is not driven while `rd_n` is low.
- R8: A data write drives `wr_n` low over the same window as a read, and drives `port_out` = write data with `port_oe` = 1 from phase 3 of the first machine cycle to the end of the access.
- R9: For a fetch or a read, `port_in` is captured on phase 6 of the last machine cycle, and `rdata` holds that value until the next capture.
- R10: `done` is high for exactly one clock, on phase 7 of the last machine cycle, the clock right after the strobe rises.
- R11: Requests are sampled only on phase 7. A request that is withdrawn before phase 7 has no effect, and a held request starts its strobe 4 to 11 clocks after it is raised.
- R12: Read has priority over write, and write has priority over code fetch. At most one of `psen_n`, `rd_n` and `wr_n` is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator rate |
| rst | input | 1 | Synchronous active-high reset |
| req_fetch | input | 1 | External code fetch request, held until done |
| req_rd | input | 1 | External data read request, held until done |
| req_wr | input | 1 | External data write request, held until done |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| stretch | input | 3 | Data access length: stretch+2 machine cycles |
| ale_off | input | 1 | Hold latch enable high while idle |
| port_in | input | 8 | Value read from the multiplexed port |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Active-low code fetch enable |
| rd_n | output | 1 | Active-low data read strobe |
| wr_n | output | 1 | Active-low data write strobe |
| port_oe | output | 1 | Drive enable for the multiplexed port |
| port_out | output | 8 | Value driven on the port |
| addr_hi | output | 8 | High address byte of the current access |
| rdata | output | 8 | Captured read data |
| done | output | 1 | One-clock pulse at the end of an access |

## Verification
The assertions check on every cycle that:
- the reset levels on `ale` and the port hold;
- no two strobes are ever low together;
- `ale` stays low while any strobe is low;
- the port floats under `rd_n` and is driven under `wr_n`;
- `done` is a single clock that directly follows a strobe;
- `rdata` changes only right after a strobe-low cycle.

Only the directed scenarios can show the rest:
- the exact strobe lengths for each stretch setting;
- the three-clock address phase that comes before the strobe;
- the idle latch-enable period and its suppression;
- the timing of the capture;
- the priority order and the request-sampling window.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_READ,
        ST_WRITE
    } bus_state_t;
endpackage

// File: rtl/xbus_phase.sv
// Phase counter: PH_PER_MC clock phases make one machine cycle.
module xbus_phase #(
    parameter int PH_PER_MC = 8,
    parameter int PH_W      = $clog2(PH_PER_MC)
) (
    input  logic            clk,
    input  logic            rst,
    output logic [PH_W-1:0] phase,
    output logic            mc_end
);
    assign mc_end = (phase == PH_W'(PH_PER_MC - 1));

    always_ff @(posedge clk) begin
        if (rst)         phase <= '0;
        else if (mc_end) phase <= '0;
        else             phase <= phase + 1'b1;
    end
endmodule

// File: rtl/xbus_mccnt.sv
// Machine-cycle counter within one access; the limit is loaded at start.
module xbus_mccnt #(
    parameter int MC_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [MC_W-1:0] lim_in,
    input  logic            adv,
    output logic            first,
    output logic            last
);
    logic [MC_W-1:0] cnt_q;
    logic [MC_W-1:0] lim_q;

    assign first = (cnt_q == '0);
    assign last  = (cnt_q == lim_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            lim_q <= lim_in;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/xbus_fsm.sv
// Access state machine: arbitration, latching, strobes, port control, capture.
module xbus_fsm
    import xbus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int STRETCH_W   = 3,
    parameter int PH_PER_MC   = 8,
    parameter int ALE_PH      = 3,
    parameter int MIN_DATA_MC = 2,
    parameter int PH_W        = $clog2(PH_PER_MC),
    parameter int MC_W        = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PH_W-1:0]      phase,
    input  logic                 mc_end,
    input  logic                 mc_first,
    input  logic                 mc_last,
    input  logic                 req_fetch,
    input  logic                 req_rd,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic                 ale_off,
    input  logic [DATA_W-1:0]    port_in,
    output logic                 start,
    output logic [MC_W-1:0]      lim,
    output logic                 adv,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 port_oe,
    output logic [DATA_W-1:0]    port_out,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done
);
    localparam logic [PH_W-1:0] CAP_PH = PH_W'(PH_PER_MC - 2);

    bus_state_t st_q, st_d;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdat_q;
    logic [DATA_W-1:0] rdat_q;

    logic busy, seq_end, take, addr_ph, strobe_win, capture;
    logic [MC_W-1:0] data_lim;

    assign busy       = (st_q != ST_IDLE);
    assign seq_end    = busy && mc_last && mc_end;
    assign take       = mc_end && (!busy || mc_last) && (req_rd || req_wr || req_fetch);
    assign addr_ph    = busy && mc_first && (phase < PH_W'(ALE_PH));
    assign strobe_win = busy && !addr_ph && !seq_end;
    assign adv        = busy && mc_end && !mc_last;
    assign data_lim   = MC_W'(MIN_DATA_MC - 1) + MC_W'(stretch);
    assign capture    = ((st_q == ST_FETCH) || (st_q == ST_READ)) && mc_last && (phase == CAP_PH);

    // next-state and arbitration: read, then write, then fetch
    always_comb begin
        st_d  = st_q;
        start = 1'b0;
        lim   = '0;
        if (take) begin
            start = 1'b1;
            if (req_rd) begin
                st_d = ST_READ;
                lim  = data_lim;
            end else if (req_wr) begin
                st_d = ST_WRITE;
                lim  = data_lim;
            end else begin
                st_d = ST_FETCH;
            end
        end else if (seq_end) begin
            st_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_IDLE;
        else     st_q <= st_d;
    end

    // access operands and read capture
    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            wdat_q <= '0;
            rdat_q <= '0;
        end else begin
            if (start) begin
                addr_q <= addr;
                wdat_q <= wdata;
            end
            if (capture) rdat_q <= port_in;
        end
    end

    // outputs
    always_comb begin
        ale      = 1'b1;
        psen_n   = 1'b1;
        rd_n     = 1'b1;
        wr_n     = 1'b1;
        port_oe  = 1'b0;
        port_out = '0;
        unique case (st_q)
            ST_IDLE: begin
                ale = ale_off || (phase < PH_W'(ALE_PH));
            end
            ST_FETCH: begin
                ale    = addr_ph;
                psen_n = !strobe_win;
            end
            ST_READ: begin
                ale  = addr_ph;
                rd_n = !strobe_win;
            end
            ST_WRITE: begin
                ale     = addr_ph;
                wr_n    = !strobe_win;
                port_oe = 1'b1;
                port_out = wdat_q;
            end
            default: ;
        endcase
        if (addr_ph) begin
            port_oe  = 1'b1;
            port_out = addr_q[DATA_W-1:0];
        end
        if (rst) begin
            ale     = 1'b1;
            port_oe = 1'b0;
            psen_n  = 1'b1;
            rd_n    = 1'b1;
            wr_n    = 1'b1;
        end
    end

    assign addr_hi = addr_q[ADDR_W-1:DATA_W];
    assign rdata   = rdat_q;
    assign done    = seq_end && !rst;
endmodule

// File: rtl/xbus_seq.sv
module xbus_seq #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int STRETCH_W   = 3,
    parameter int PH_PER_MC   = 8,
    parameter int ALE_PH      = 3,
    parameter int MIN_DATA_MC = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_fetch,
    input  logic                 req_rd,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [STRETCH_W-1:0] stretch,
    input  logic                 ale_off,
    input  logic [DATA_W-1:0]    port_in,
    output logic                 ale,
    output logic                 psen_n,
    output logic                 rd_n,
    output logic                 wr_n,
    output logic                 port_oe,
    output logic [DATA_W-1:0]    port_out,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]    rdata,
    output logic                 done
);
    localparam int PH_W = $clog2(PH_PER_MC);
    localparam int MC_W = $clog2(MIN_DATA_MC + (1 << STRETCH_W));

    logic [PH_W-1:0] phase;
    logic            mc_end, mc_first, mc_last, start, adv;
    logic [MC_W-1:0] lim;

    xbus_phase #(.PH_PER_MC(PH_PER_MC), .PH_W(PH_W)) u_phase (
        .clk(clk), .rst(rst), .phase(phase), .mc_end(mc_end)
    );

    xbus_mccnt #(.MC_W(MC_W)) u_mccnt (
        .clk(clk), .rst(rst), .start(start), .lim_in(lim), .adv(adv),
        .first(mc_first), .last(mc_last)
    );

    xbus_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STRETCH_W(STRETCH_W),
        .PH_PER_MC(PH_PER_MC), .ALE_PH(ALE_PH), .MIN_DATA_MC(MIN_DATA_MC),
        .PH_W(PH_W), .MC_W(MC_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .phase(phase), .mc_end(mc_end),
        .mc_first(mc_first), .mc_last(mc_last),
        .req_fetch(req_fetch), .req_rd(req_rd), .req_wr(req_wr),
        .addr(addr), .wdata(wdata), .stretch(stretch), .ale_off(ale_off),
        .port_in(port_in), .start(start), .lim(lim), .adv(adv),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .port_oe(port_oe), .port_out(port_out), .addr_hi(addr_hi),
        .rdata(rdata), .done(done)
    );
endmodule

// File: rtl/xbus_seq_chk.sv
module xbus_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ale,
    input logic              psen_n,
    input logic              rd_n,
    input logic              wr_n,
    input logic              port_oe,
    input logic              done,
    input logic [DATA_W-1:0] rdata
);
    logic any_low;
    assign any_low = !(psen_n && rd_n && wr_n);

    a_r2_reset_levels: assert property (@(posedge clk)
        rst |-> (ale && !port_oe && !any_low && !done));

    a_r12_one_strobe: assert property (@(posedge clk) disable iff (rst)
        $countones({~psen_n, ~rd_n, ~wr_n}) <= 1);

    a_r4_ale_low_in_strobe: assert property (@(posedge clk) disable iff (rst)
        any_low |-> !ale);

    a_r7_read_floats: assert property (@(posedge clk) disable iff (rst)
        !rd_n |-> !port_oe);

    a_r8_write_drives: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> port_oe);

    a_r10_done_after_strobe: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(any_low) && !any_low));

    a_r10_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (rst)
        $past(psen_n && rd_n) |-> $stable(rdata));
endmodule

bind xbus_seq xbus_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .ale(ale), .psen_n(psen_n), .rd_n(rd_n),
    .wr_n(wr_n), .port_oe(port_oe), .done(done), .rdata(rdata)
);

// File: tb/tb_xbus_seq.sv
module tb_xbus_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_fetch = 1'b0, req_rd = 1'b0, req_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [2:0]  stretch = '0;
    logic        ale_off = 1'b0;
    logic [7:0]  port_in = '0;
    logic        ale, psen_n, rd_n, wr_n, port_oe, done;
    logic [7:0]  port_out, addr_hi, rdata;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    xbus_seq dut (
        .clk(clk), .rst(rst), .req_fetch(req_fetch), .req_rd(req_rd), .req_wr(req_wr),
        .addr(addr), .wdata(wdata), .stretch(stretch), .ale_off(ale_off),
        .port_in(port_in), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .port_oe(port_oe), .port_out(port_out), .addr_hi(addr_hi),
        .rdata(rdata), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // R2: levels during reset, with a fetch request already raised
    task automatic t_reset();
        req_fetch = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(ale && !port_oe && psen_n && rd_n && wr_n && !done, "R2 reset levels",
                {ale, port_oe, psen_n, rd_n, wr_n, done}, 6'b101110);
        end
        req_fetch = 1'b0;
        rst = 1'b0;
    endtask

    // R1 and R3: idle latch-enable pattern
    task automatic t_idle_ale();
        logic [23:0] h;
        int highs = 0;
        int rises = 0;
        bit per_ok = 1'b1;
        ale_off = 1'b0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk);
            h[i] = ale;
        end
        for (int i = 0; i < 24; i++) highs += int'(h[i]);
        for (int i = 8; i < 24; i++) if (h[i] != h[i-8]) per_ok = 1'b0;
        for (int i = 1; i < 9; i++) if (h[i] && !h[i-1]) rises++;
        chk(highs == 9, "R1 ale high count over 24 clocks", highs, 9);
        chk(per_ok, "R1 ale period 8", int'(per_ok), 1);
        chk(rises == 1, "R1 one ale pulse per machine cycle", rises, 1);
        ale_off = 1'b1;
        highs = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            highs += int'(ale);
        end
        chk(highs == 20, "R3 ale held high when suppressed", highs, 20);
    endtask

    // kind: 0 fetch, 1 read, 2 write
    task automatic run_access(input int kind, input logic [15:0] a, input logic [7:0] wd,
                              input logic [2:0] st, input logic dis_v, input logic [7:0] rv);
        int exp_low = (kind == 0) ? 4 : 8 * (int'(st) + 2) - 4;
        int first = -1;
        int lowc = 0;
        int done_c = -1;
        logic [2:0] hist = '0;
        bit addr_ok = 1'b0;
        bit ale_bad = 1'b0, port_bad = 1'b0, other_bad = 1'b0, hi_bad = 1'b0, wdone_ok = 1'b1;
        logic s;
        int others;
        addr = a; wdata = wd; stretch = st; ale_off = dis_v; port_in = ~rv;
        if (kind == 0) req_fetch = 1'b1;
        else if (kind == 1) req_rd = 1'b1;
        else req_wr = 1'b1;
        for (int c = 1; c <= 300; c++) begin
            @(negedge clk);
            s = (kind == 0) ? !psen_n : (kind == 1) ? !rd_n : !wr_n;
            others = int'(!psen_n) + int'(!rd_n) + int'(!wr_n) - int'(s);
            if (others != 0) other_bad = 1'b1;
            if (s) begin
                if (first < 0) begin
                    first = c;
                    addr_ok = (hist == 3'b111);
                end
                lowc++;
                if (ale) ale_bad = 1'b1;
                if (addr_hi != a[15:8]) hi_bad = 1'b1;
                if (kind == 2 && !(port_oe && port_out == wd)) port_bad = 1'b1;
                if (kind != 2 && port_oe) port_bad = 1'b1;
            end
            if (done) begin
                done_c = c;
                if (kind == 2) wdone_ok = port_oe && (port_out == wd);
                req_fetch = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
                port_in = ~rv;
                break;
            end
            hist = {hist[1:0], ale && port_oe && (port_out == a[7:0])};
            port_in = s ? rv : ~rv;
        end
        chk(done_c > 0, "R10 access completes", done_c, 1);
        if (kind == 0) chk(lowc == exp_low, "R6 psen_n low length", lowc, exp_low);
        else if (kind == 1) chk(lowc == exp_low, "R7 rd_n low length", lowc, exp_low);
        else chk(lowc == exp_low, "R8 wr_n low length", lowc, exp_low);
        chk(done_c == first + lowc, "R10 done right after strobe", done_c, first + lowc);
        chk(addr_ok, "R5 address byte with ale before strobe", int'(hist), 7);
        chk(!hi_bad, "R5 high address byte", int'(addr_hi), int'(a[15:8]));
        chk(!ale_bad, "R4 ale low during strobe", 1, 0);
        chk(!other_bad, "R12 single strobe", 1, 0);
        chk(first >= 4 && first <= 11, "R11 start latency", first, 4);
        if (kind == 2) begin
            chk(!port_bad && wdone_ok, "R8 write data driven", int'(port_out), int'(wd));
        end else begin
            chk(!port_bad, "R7 port floats during read strobe", 1, 0);
        end
        @(negedge clk);
        chk(!done, "R10 done single clock", int'(done), 0);
        if (kind != 2) chk(rdata == rv, "R9 captured data", int'(rdata), int'(rv));
        else chk(psen_n && rd_n && wr_n, "R6 strobes high after access", 0, 1);
    endtask

    // R11: request withdrawn before phase 7 is ignored
    task automatic t_ignored();
        int lows = 0;
        ale_off = 1'b0;
        @(negedge clk);
        while (!ale) @(negedge clk);
        while (ale) @(negedge clk);
        req_fetch = 1'b1;
        @(negedge clk);
        @(negedge clk);
        req_fetch = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            lows += int'(!psen_n) + int'(done);
        end
        chk(lows == 0, "R11 short request ignored", lows, 0);
    endtask

    // R12: priority read > write > fetch
    task automatic t_priority();
        int order[3];
        int n = 0;
        int cur = -1;
        stretch = 3'd0;
        ale_off = 1'b0;
        req_fetch = 1'b1; req_rd = 1'b1; req_wr = 1'b1;
        for (int c = 0; c < 400 && n < 4; c++) begin
            @(negedge clk);
            if (cur < 0) begin
                if (!rd_n) cur = 1;
                else if (!wr_n) cur = 2;
                else if (!psen_n) cur = 0;
                if (cur >= 0 && n < 3) begin
                    order[n] = cur;
                    n++;
                end
            end
            if (done) begin
                if (cur == 0) req_fetch = 1'b0;
                if (cur == 1) req_rd = 1'b0;
                if (cur == 2) req_wr = 1'b0;
                cur = -1;
                if (n == 3) n = 4;
            end
        end
        req_fetch = 1'b0; req_rd = 1'b0; req_wr = 1'b0;
        chk(n == 4 && order[0] == 1 && order[1] == 2 && order[2] == 0,
            "R12 priority order", order[0] * 100 + order[1] * 10 + order[2], 120);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_idle_ale();
        run_access(0, 16'h12A5, 8'h00, 3'd0, 1'b0, 8'h3C);
        run_access(0, 16'h7E01, 8'h00, 3'd5, 1'b1, 8'hC7);
        run_access(1, 16'hBE5A, 8'h00, 3'd0, 1'b0, 8'h96);
        run_access(1, 16'h0480, 8'h00, 3'd7, 1'b1, 8'h5B);
        run_access(2, 16'hF00F, 8'hA1, 3'd3, 1'b0, 8'h00);
        run_access(2, 16'h33CC, 8'h4E, 3'd0, 1'b1, 8'h00);
        t_ignored();
        t_priority();
        summary();
        $finish;
    end
endmodule